// File: doc/BRIEF.md
# Packed-Control Performance Monitor

This block counts hardware activity for profiling. It has one free-running cycle counter and two 32-bit event counters. Each event counter chooses one input from a vector of single-cycle event strobes by an 8-bit event code. A single packed control/status word configures the block. It holds the global run bit, two self-clearing reset commands, an optional slow cycle clock, the per-counter interrupt enables, the per-counter sticky overflow flags and both event codes.

Software drives the block through a plain register port. A write takes effect at the clock edge where `reg_we` is high. Reads come back combinationally for the address presented. Each overflow flag is cleared by writing a one into its bit position. Software can therefore read the control word, modify it and write it back, and that single write also acknowledges the interrupts it saw. A level interrupt stays high while any flag whose enable is set is still pending.

Top module: `perfmon_unit`

## Requirements
- R1: After synchronous reset, the control word, all three counters and `irq` read as zero.
- R2: The control word (address 0) is laid out as follows:
  - bit 0: run enable
  - bit 3: slow cycle mode
  - bits 4/5/6: interrupt enables for event counter 0, event counter 1 and the cycle counter
  - bits 8/9/10: overflow flags, in the same counter order
  - bits 12–19: event code of counter 0
  - bits 20–27: event code of counter 1

  Bits 1, 2, 7, 11 and 28–31 always read as zero.
- R3: While bit 0 is set, an event counter adds one on every clock edge where the strobe selected by its event code (strobe index = code) is high. While bit 0 is clear, it holds its value.
- R4: An event counter whose code is 0xFF never increments, whatever the strobes do.
- R5: While bit 0 is set, the cycle counter adds one per clock. With bit 3 also set, it adds one on every 64th enabled clock, the first increment falling on the 64th enabled edge after the cycle counter was last reset.
- R6: Writing bit 1 as one zeroes both event counters at that edge and leaves the cycle counter untouched. Writing bit 2 as one zeroes the cycle counter and its 64-clock divider and leaves the event counters untouched.
- R7: A counter that increments from 0xFFFFFFFF to 0 sets its overflow flag (bit 8, 9 or 10).
- R8: Overflow flags are sticky and independent. A flag is cleared only by a control write with a one in its bit. Writing zero there, or an overflow on another counter, leaves it set.
- R9: `irq` is high exactly while some overflow flag and its matching enable (bits 4–6) are both set. It stays high until software clears the flag or the enable.
- R10: Addresses 1, 2 and 3 read and write the cycle counter, event counter 0 and event counter 1. A write to a counter takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_strobe | input | SRC_W (32) | One-cycle event pulses, bit n is event code n |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 cycle, 2 event 0, 3 event 1 |
| reg_wdata | input | DATA_W (32) | Register write data |
| reg_rdata | output | DATA_W (32) | Combinational read data for `reg_addr` |
| irq | output | 1 | Level interrupt |

## Verification
The properties check the following on every cycle:
- the reserved and self-clearing control bits read as zero;
- no pending flag drops without a one written to it;
- `irq` holds between control writes;
- an unused-coded event counter never moves;
- a counter write lands exactly;
- a cycle-counter wrap raises its flag.

Only the directed scenarios can show the following:
- exact increment counts per selected strobe;
- the 64-clock spacing of slow mode;
- that each reset command reaches only its own counters;
- the masking of `irq` by the enables;
- the read-modify-write acknowledge sequence across two pending flags.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

    localparam int REG_W   = 32;
    localparam int CODE_W  = 8;
    localparam int NUM_EVT = 2;
    localparam int NUM_CNT = NUM_EVT + 1;

    // counter slots, also the order of enable and flag bits
    localparam int IDX_EV0 = 0;
    localparam int IDX_EV1 = 1;
    localparam int IDX_CYC = 2;

    // control word field positions
    localparam int B_RUN   = 0;
    localparam int B_EVCLR = 1;
    localparam int B_CYCLR = 2;
    localparam int B_SLOW  = 3;
    localparam int B_IE    = 4;
    localparam int B_FLAG  = 8;
    localparam int B_SEL0  = 12;
    localparam int B_SEL1  = 20;

    localparam logic [CODE_W-1:0] CODE_IDLE = 8'hFF;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_CYC  = 2'd1,
        A_EV0  = 2'd2,
        A_EV1  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [NUM_EVT-1:0][CODE_W-1:0] sel;
        logic [NUM_CNT-1:0]             flag;
        logic [NUM_CNT-1:0]             ie;
        logic                           slow;
        logic                           run;
    } ctrl_t;

    function automatic logic [REG_W-1:0] ctrl_pack(input ctrl_t c);
        logic [REG_W-1:0] v;
        v                  = '0;
        v[B_RUN]           = c.run;
        v[B_SLOW]          = c.slow;
        v[B_IE +: NUM_CNT]   = c.ie;
        v[B_FLAG +: NUM_CNT] = c.flag;
        v[B_SEL0 +: CODE_W]  = c.sel[0];
        v[B_SEL1 +: CODE_W]  = c.sel[1];
        return v;
    endfunction

    function automatic reg_addr_e cnt_addr(input int idx);
        case (idx)
            IDX_EV0: return A_EV0;
            IDX_EV1: return A_EV1;
            default: return A_CYC;
        endcase
    endfunction

endpackage

// File: rtl/perfmon_evsel.sv
module perfmon_evsel
    import perfmon_pkg::*;
#(
    parameter int SRC_W = 32
) (
    input  logic [CODE_W-1:0] code,
    input  logic [SRC_W-1:0]  strobes,
    output logic              hit
);
    localparam int IDX_W = (SRC_W > 1) ? $clog2(SRC_W) : 1;

    logic in_range;
    logic [IDX_W-1:0] pick;

    always_comb begin
        in_range = (code != CODE_IDLE) && (32'(code) < SRC_W);
        pick     = IDX_W'(code);
        hit      = in_range && strobes[pick];
    end
endmodule

// File: rtl/perfmon_counter.sv
module perfmon_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (wr)  cnt <= wdata;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    assign wrap = inc && !wr && !clr && (cnt == '1);
endmodule

// File: rtl/perfmon_prescale.sv
module perfmon_prescale #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    output logic tick
);
    localparam int PS_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PS_W-1:0] LAST = PS_W'(DIV - 1);

    logic [PS_W-1:0] ps;

    assign tick = step && (ps == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) ps <= '0;
        else if (tick)  ps <= '0;
        else if (step)  ps <= ps + 1'b1;
    end
endmodule

// File: rtl/perfmon_ctrl.sv
module perfmon_ctrl
    import perfmon_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [REG_W-1:0]   wdata,
    input  logic [NUM_CNT-1:0] wrap,
    output ctrl_t              cfg,
    output logic               evt_clr,
    output logic               cyc_clr,
    output logic               irq
);
    logic [NUM_CNT-1:0] ack;

    assign ack     = we ? wdata[B_FLAG +: NUM_CNT] : '0;
    assign evt_clr = we && wdata[B_EVCLR];
    assign cyc_clr = we && wdata[B_CYCLR];
    assign irq     = |(cfg.flag & cfg.ie);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else begin
            if (we) begin
                cfg.run    <= wdata[B_RUN];
                cfg.slow   <= wdata[B_SLOW];
                cfg.ie     <= wdata[B_IE +: NUM_CNT];
                cfg.sel[0] <= wdata[B_SEL0 +: CODE_W];
                cfg.sel[1] <= wdata[B_SEL1 +: CODE_W];
            end
            // a fresh wrap wins over an acknowledge in the same cycle
            cfg.flag <= (cfg.flag & ~ack) | wrap;
        end
    end
endmodule

// File: rtl/perfmon_unit.sv
module perfmon_unit
    import perfmon_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SRC_W   = 32,
    parameter int CYC_DIV = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_W-1:0]  evt_strobe,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    ctrl_t                          cfg;
    logic                           evt_clr;
    logic                           cyc_clr;
    logic                           ctrl_we;
    logic                           slow_tick;
    logic [NUM_CNT-1:0]             wrap;
    logic [NUM_CNT-1:0]             inc;
    logic [NUM_CNT-1:0]             cnt_we;
    logic [NUM_CNT-1:0][DATA_W-1:0] cnt_q;

    assign ctrl_we = reg_we && (reg_addr == A_CTRL);

    perfmon_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .we      (ctrl_we),
        .wdata   (REG_W'(reg_wdata)),
        .wrap    (wrap),
        .cfg     (cfg),
        .evt_clr (evt_clr),
        .cyc_clr (cyc_clr),
        .irq     (irq)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_we
        assign cnt_we[i] = reg_we && (reg_addr == cnt_addr(i));
    end

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
        logic hit;

        perfmon_evsel #(.SRC_W(SRC_W)) u_sel (
            .code    (cfg.sel[i]),
            .strobes (evt_strobe),
            .hit     (hit)
        );

        assign inc[i] = cfg.run && hit;

        perfmon_counter #(.W(DATA_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .clr   (evt_clr),
            .wr    (cnt_we[i]),
            .wdata (reg_wdata),
            .inc   (inc[i]),
            .cnt   (cnt_q[i]),
            .wrap  (wrap[i])
        );
    end

    perfmon_prescale #(.DIV(CYC_DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .clr  (cyc_clr),
        .step (cfg.run && cfg.slow),
        .tick (slow_tick)
    );

    assign inc[IDX_CYC] = cfg.run && (cfg.slow ? slow_tick : 1'b1);

    perfmon_counter #(.W(DATA_W)) u_cyc (
        .clk   (clk),
        .rst   (rst),
        .clr   (cyc_clr),
        .wr    (cnt_we[IDX_CYC]),
        .wdata (reg_wdata),
        .inc   (inc[IDX_CYC]),
        .cnt   (cnt_q[IDX_CYC]),
        .wrap  (wrap[IDX_CYC])
    );

    always_comb begin
        case (reg_addr_e'(reg_addr))
            A_CTRL:  reg_rdata = DATA_W'(ctrl_pack(cfg));
            A_CYC:   reg_rdata = cnt_q[IDX_CYC];
            A_EV0:   reg_rdata = cnt_q[IDX_EV0];
            default: reg_rdata = cnt_q[IDX_EV1];
        endcase
    end
endmodule

// File: rtl/perfmon_checker.sv
module perfmon_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [1:0]        reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq,
    input logic [2:0]        flag_q,
    input logic [7:0]        sel0_q,
    input logic [DATA_W-1:0] ev0_cnt,
    input logic [DATA_W-1:0] cyc_cnt
);
    localparam logic [31:0] RSVD_MASK = 32'hF000_0886;

    logic       ctrl_wr;
    logic [2:0] keep_flags;

    assign ctrl_wr    = reg_we && (reg_addr == 2'd0);
    assign keep_flags = flag_q & ~(ctrl_wr ? reg_wdata[10:8] : 3'b000);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 2'd0) |-> ((32'(reg_rdata) & RSVD_MASK) == 32'h0)); // R2

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flag_q & $past(keep_flags)) == $past(keep_flags))); // R8

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq && !ctrl_wr) |=> irq); // R9

    AST_IDLE_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sel0_q == 8'hFF && !reg_we) |=> $stable(ev0_cnt)); // R4

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == 2'd1) |=> (cyc_cnt == $past(reg_wdata))); // R10

    AST_CYC_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
        ($past(cyc_cnt) == '1 && cyc_cnt == '0 && !$past(reg_we)) |-> flag_q[2]); // R7
endmodule

bind perfmon_unit perfmon_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .flag_q    (cfg.flag),
    .sel0_q    (cfg.sel[0]),
    .ev0_cnt   (cnt_q[0]),
    .cyc_cnt   (cnt_q[2])
);

// File: tb/perfmon_unit_tb.sv
module perfmon_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] AC = 2'd0, AY = 2'd1, AE0 = 2'd2, AE1 = 2'd3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] evt_strobe = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    perfmon_unit u_dut (
        .clk        (clk),
        .rst        (rst),
        .evt_strobe (evt_strobe),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq        (irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic t_reset();
        rd_chk("R1 ctrl", AC, 32'h0);
        rd_chk("R1 cyc", AY, 32'h0);
        rd_chk("R1 ev0", AE0, 32'h0);
        rd_chk("R1 ev1", AE1, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_layout_idle();
        wr(AC, 32'hFFFF_FFFF);
        rd_chk("R2 readback masks reserved and reset bits", AC, 32'h0FFF_F079);
        evt_strobe = '1;
        repeat (10) @(negedge clk);
        evt_strobe = '0;
        rd_chk("R4 ev0 with code FF", AE0, 32'h0);
        rd_chk("R4 ev1 with code FF", AE1, 32'h0);
        wr(AC, 32'h0);
    endtask

    task automatic t_events();
        wr(AC, 32'h0050_7007);
        for (int i = 0; i < 8; i++) begin
            evt_strobe = 32'h40;
            if (i < 5) evt_strobe[7] = 1'b1;
            if (i < 3) evt_strobe[5] = 1'b1;
            @(negedge clk);
        end
        evt_strobe = '0;
        wr(AC, 32'h0050_7000);
        rd_chk("R3 ev0 counts code 07", AE0, 32'd5);
        rd_chk("R3 ev1 counts code 05", AE1, 32'd3);
        for (int i = 0; i < 3; i++) begin
            evt_strobe = 32'hA0;
            @(negedge clk);
        end
        evt_strobe = '0;
        rd_chk("R3 ev0 holds while stopped", AE0, 32'd5);
    endtask

    task automatic t_cycles();
        wr(AC, 32'h4);
        wr(AC, 32'h1);
        repeat (20) @(negedge clk);
        rd_chk("R5 cycle count running", AY, 32'd20);
        wr(AC, 32'h0);
        repeat (10) @(negedge clk);
        rd_chk("R5 cycle count stopped", AY, 32'd21);
    endtask

    task automatic t_reset_cmds();
        wr(AC, 32'h2);
        rd_chk("R6 event reset clears ev0", AE0, 32'h0);
        rd_chk("R6 event reset clears ev1", AE1, 32'h0);
        rd_chk("R6 event reset spares cyc", AY, 32'd21);
        wr(AC, 32'h4);
        rd_chk("R6 cycle reset clears cyc", AY, 32'h0);
    endtask

    task automatic t_slow();
        wr(AC, 32'h4);
        wr(AC, 32'h9);
        repeat (63) @(negedge clk);
        rd_chk("R5 slow mode before 64th clock", AY, 32'd0);
        @(negedge clk);
        rd_chk("R5 slow mode at 64th clock", AY, 32'd1);
        repeat (64) @(negedge clk);
        rd_chk("R5 slow mode at 128th clock", AY, 32'd2);
        wr(AC, 32'h0);
    endtask

    task automatic t_overflow_irq();
        wr(AC, 32'h0030_2010);
        wr(AE0, 32'hFFFF_FFFF);
        wr(AE1, 32'hFFFF_FFFF);
        wr(AC, 32'h0030_2011);
        evt_strobe = 32'h4; @(negedge clk); evt_strobe = '0;
        rd_chk("R7 ev0 wraps to zero", AE0, 32'h0);
        rd_chk("R7 ev0 flag set", AC, 32'h0030_2111);
        check("R9 irq on enabled flag", {31'h0, irq}, 32'h1);
        evt_strobe = 32'h8; @(negedge clk); evt_strobe = '0;
        rd_chk("R8 second overflow keeps first flag", AC, 32'h0030_2311);
        wr(AC, 32'h0030_2111);
        rd_chk("R8 ack one flag only", AC, 32'h0030_2211);
        check("R9 irq masked for disabled flag", {31'h0, irq}, 32'h0);
        wr(AC, 32'h0030_2031);
        rd_chk("R8 zero write keeps flag", AC, 32'h0030_2231);
        check("R9 irq after enabling", {31'h0, irq}, 32'h1);
        repeat (3) @(negedge clk);
        check("R9 irq level holds", {31'h0, irq}, 32'h1);
        wr(AC, 32'h0030_2231);
        rd_chk("R8 ack second flag", AC, 32'h0030_2031);
        check("R9 irq drops after ack", {31'h0, irq}, 32'h0);
        wr(AC, 32'h0);
    endtask

    task automatic t_cyc_wrap();
        wr(AY, 32'hFFFF_FFFD);
        wr(AC, 32'h41);
        repeat (2) @(negedge clk);
        rd_chk("R7 cyc before wrap", AY, 32'hFFFF_FFFF);
        check("R9 no irq before wrap", {31'h0, irq}, 32'h0);
        @(negedge clk);
        rd_chk("R7 cyc wraps", AY, 32'h0);
        rd_chk("R7 cyc flag", AC, 32'h0000_0441);
        check("R9 irq on cyc wrap", {31'h0, irq}, 32'h1);
        wr(AC, 32'h400);
        check("R9 irq cleared", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_write_priority();
        wr(AC, 32'h0FF0_9001);
        evt_strobe = 32'h200;
        reg_we = 1'b1; reg_addr = AE0; reg_wdata = 32'h100;
        @(negedge clk);
        reg_we = 1'b0; evt_strobe = '0;
        rd_chk("R10 write wins over increment", AE0, 32'h100);
        evt_strobe = 32'h200; @(negedge clk); evt_strobe = '0;
        rd_chk("R10 counting resumes after write", AE0, 32'h101);
        wr(AC, 32'h0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_layout_idle();
        t_events();
        t_cycles();
        t_reset_cmds();
        t_slow();
        t_overflow_irq();
        t_cyc_wrap();
        t_write_priority();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule